// File: doc/BRIEF.md
# HDLC Receive Deframer

This block recovers HDLC frames from a serial bit stream taken out of the payload bits of a framed line. Each incoming bit is qualified by a valid strobe. The block removes stuffed zeros, locates flag octets and builds octets LSB-first onto a byte-wide output bus with a byte strobe. It also checks the CRC-16 trailer of each frame. Flag octets appear on the same bus as payload octets, so the consumer sees every flag on the line.

Two status lines report frame events, and their meaning depends on how they are combined. On a flag octet the idle line is high. The FCS line is also high when that flag closes a frame whose check sequence is correct. When the FCS line is high and the idle line is low, with no byte strobe, an abort was received. Octets are emitted before the block knows whether their frame will end well. The consumer therefore holds them until the closing status arrives. The two FCS octets are passed through like any other octet.

Top module: `hdlcRxDeframer`

## Requirements
- R1: While reset is asserted and after its release, `byteStrobe`, `idleFlag` and `fcsGood` are low. The receiver starts in hunt state, so the first flag it sees is reported as a plain flag with `fcsGood` low.
- R2: A received 0 that follows exactly six consecutive 1s is a flag. One clock later, `byteStrobe` and `idleFlag` pulse high for one cycle and `dataOut` is 0x7E.
- R3: A received 0 that follows exactly five consecutive 1s is a stuffed bit. It is deleted and counts toward no octet.
- R4: Between an opening flag and the next event, every eighth kept bit completes an octet. Bits are assembled first-received into bit 0. One clock after the completing bit, the octet is on `dataOut` with `byteStrobe` high and both `idleFlag` and `fcsGood` low. FCS octets are included.
- R5: A flag closes a good frame when all of the following hold: at least two octets arrived since the previous flag, the bit count is a whole number of octets, and the CRC-CCITT residue over all octets equals 0xF0B8. The CRC is reflected, polynomial 0x8408, preset 0xFFFF. For such a flag, `idleFlag` and `fcsGood` are both high.
- R6: A flag that closes a whole-octet frame of two or more octets with a wrong FCS shows `idleFlag` high and `fcsGood` low.
- R7: Seven consecutive 1s while not hunting is an abort. One clock after the seventh 1, `fcsGood` is high for one cycle, with `idleFlag` low and `byteStrobe` low.
- R8: After an abort the receiver hunts. It emits no octet and no status until the next flag, and that flag is reported as a plain flag.
- R9: A closing flag after fewer than two octets never raises `fcsGood`. Exactly two octets, made up only of the FCS of an empty payload, form a good frame.
- R10: A closing flag whose bit count since the previous flag is not a whole number of octets never raises `fcsGood`.
- R11: A single flag may close one frame and open the next, and both frames are judged on their own.
- R12: A cycle with `bitValid` low changes no receiver state and produces no pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Received line bit |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| dataOut | output | 8 | Received octet or flag octet, held between strobes |
| byteStrobe | output | 1 | One-cycle pulse: `dataOut` carries a new octet |
| idleFlag | output | 1 | One-cycle pulse: the octet on `dataOut` is a flag |
| fcsGood | output | 1 | With `idleFlag`: good frame closed; without it: abort |

## Verification
The stream starts with back-to-back idle flags, which separate hunt exit from plain flag reporting. It then carries frames whose payloads hold runs of five and six 1s, so stuffed-zero deletion shows up directly in the octet values. Good, corrupted, one-octet and FCS-only frames that share flags probe where the good/bad verdict boundary lies. One frame ends three bits past an octet boundary and is followed by a flag, which exposes the misalignment rule and the partial octet that leaks out before the flag. Two further patterns work on receiver state: one frame is driven with idle cycles between bits while `bitIn` toggles, and an abort is followed by hunt-time data. Together they show that invalid cycles and hunting leave no trace on the outputs.

// File: rtl/hdlcRxPkg.sv
package hdlcRxPkg;

  // Value of the flag octet on the output bus.
  localparam logic [7:0] FLAG_OCTET = 8'h7E;

  // Strobes from control to datapath, all valid in the cycle of a bit.
  typedef struct packed {
    logic pushBit;    // bit is kept (not a stuffed zero)
    logic emitByte;   // this bit completes a payload octet
    logic emitFlag;   // this bit completes a flag
    logic frameGood;  // the flag closes a frame with a correct FCS
    logic emitAbort;  // seventh consecutive one while in frame
  } rxCtl_t;

endpackage

// File: rtl/hdlcRxCtrl.sv
module hdlcRxCtrl
  import hdlcRxPkg::*;
#(
  parameter int FLAG_RUN   = 6,
  parameter int MIN_OCTETS = 2,
  parameter int OCTET_W    = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitIn,
  input  logic   bitValid,
  input  logic   crcOk,
  output rxCtl_t ctl
);

  localparam int STUFF_RUN = FLAG_RUN - 1;
  localparam int ONES_SAT  = FLAG_RUN + 1;
  localparam int ONES_W    = $clog2(ONES_SAT + 1);
  localparam int POS_W     = $clog2(OCTET_W);
  localparam int CNT_W     = $clog2(MIN_OCTETS + 1);

  logic [ONES_W-1:0] onesRun;
  logic              hunting;
  logic [POS_W-1:0]  bitPos;
  logic [CNT_W-1:0]  octetCnt;

  logic sawFlag, sawStuff, sawAbort, lastPos, enough;

  always_comb begin
    sawFlag  = bitValid & ~bitIn & (onesRun == ONES_W'(FLAG_RUN));
    sawStuff = bitValid & ~bitIn & (onesRun == ONES_W'(STUFF_RUN));
    sawAbort = bitValid & bitIn & (onesRun == ONES_W'(FLAG_RUN)) & ~hunting;
    lastPos  = (bitPos == POS_W'(OCTET_W - 1));
    enough   = (octetCnt >= CNT_W'(MIN_OCTETS));

    ctl.pushBit   = bitValid & ~sawStuff;
    ctl.emitFlag  = sawFlag;
    ctl.emitAbort = sawAbort;
    ctl.frameGood = sawFlag & ~hunting & lastPos & enough & crcOk;
    ctl.emitByte  = bitValid & ~sawStuff & ~hunting & ~sawFlag & ~sawAbort & lastPos;
  end

  // Run length of consecutive ones, saturating above the abort length.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesRun <= '0;
    end else if (bitValid) begin
      if (!bitIn)                              onesRun <= '0;
      else if (onesRun != ONES_W'(ONES_SAT))   onesRun <= onesRun + 1'b1;
    end
  end

  // Hunt / in-frame state and octet alignment.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hunting  <= 1'b1;
      bitPos   <= '0;
      octetCnt <= '0;
    end else begin
      if (sawAbort)     hunting <= 1'b1;
      else if (sawFlag) hunting <= 1'b0;

      if (sawFlag) begin
        bitPos <= '0;
      end else if (ctl.pushBit && !hunting) begin
        bitPos <= lastPos ? '0 : bitPos + 1'b1;
      end

      if (sawFlag)                        octetCnt <= '0;
      else if (ctl.emitByte && !enough)   octetCnt <= octetCnt + 1'b1;
    end
  end

endmodule

// File: rtl/hdlcRxPath.sv
module hdlcRxPath
  import hdlcRxPkg::*;
#(
  parameter int               OCTET_W     = 8,
  parameter int               CRC_W       = 16,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  rxCtl_t             ctl,
  output logic               crcOk,
  output logic [OCTET_W-1:0] dataOut,
  output logic               byteStrobe,
  output logic               idleFlag,
  output logic               fcsGood
);

  logic [OCTET_W-1:0] shiftWin;
  logic [OCTET_W-1:0] nextWin;
  logic [CRC_W-1:0]   crcReg;
  logic [CRC_W-1:0]   crcChain [OCTET_W+1];

  // First-received bit ends up in bit 0 once an octet is complete.
  assign nextWin = {bitIn, shiftWin[OCTET_W-1:1]};

  // Reflected CRC, one stage per bit of the completed octet.
  assign crcChain[0] = crcReg;
  for (genvar g = 0; g < OCTET_W; g++) begin : gCrcStage
    assign crcChain[g+1] = (crcChain[g] >> 1) ^
                           ((crcChain[g][0] ^ nextWin[g]) ? CRC_POLY : '0);
  end

  assign crcOk = (crcReg == CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftWin <= '0;
      crcReg   <= CRC_INIT;
    end else begin
      if (ctl.pushBit) shiftWin <= nextWin;
      if (ctl.emitFlag)      crcReg <= CRC_INIT;
      else if (ctl.emitByte) crcReg <= crcChain[OCTET_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut    <= '0;
      byteStrobe <= 1'b0;
      idleFlag   <= 1'b0;
      fcsGood    <= 1'b0;
    end else begin
      byteStrobe <= ctl.emitByte | ctl.emitFlag;
      idleFlag   <= ctl.emitFlag;
      fcsGood    <= ctl.frameGood | ctl.emitAbort;
      if (ctl.emitByte || ctl.emitFlag) dataOut <= nextWin;
    end
  end

endmodule

// File: rtl/hdlcRxDeframer.sv
module hdlcRxDeframer
  import hdlcRxPkg::*;
#(
  parameter int OCTET_W    = 8,
  parameter int FLAG_RUN   = 6,
  parameter int MIN_OCTETS = 2,
  parameter int CRC_W      = 16,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               bitValid,
  output logic [OCTET_W-1:0] dataOut,
  output logic               byteStrobe,
  output logic               idleFlag,
  output logic               fcsGood
);

  rxCtl_t ctl;
  logic   crcOk;

  hdlcRxCtrl #(
    .FLAG_RUN  (FLAG_RUN),
    .MIN_OCTETS(MIN_OCTETS),
    .OCTET_W   (OCTET_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitIn   (bitIn),
    .bitValid(bitValid),
    .crcOk   (crcOk),
    .ctl     (ctl)
  );

  hdlcRxPath #(
    .OCTET_W    (OCTET_W),
    .CRC_W      (CRC_W),
    .CRC_POLY   (CRC_POLY),
    .CRC_INIT   (CRC_INIT),
    .CRC_RESIDUE(CRC_RESIDUE)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .ctl       (ctl),
    .crcOk     (crcOk),
    .dataOut   (dataOut),
    .byteStrobe(byteStrobe),
    .idleFlag  (idleFlag),
    .fcsGood   (fcsGood)
  );

endmodule

// File: rtl/hdlcRxChecker.sv
module hdlcRxChecker
  import hdlcRxPkg::*;
#(
  parameter int OCTET_W    = 8,
  parameter int MIN_OCTETS = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               bitValid,
  input logic [OCTET_W-1:0] dataOut,
  input logic               byteStrobe,
  input logic               idleFlag,
  input logic               fcsGood
);

  localparam int CNT_W = $clog2(MIN_OCTETS + 1);

  logic [CNT_W-1:0] octSince;
  logic             huntTrack;

  // Octets seen on the bus since the last flag, and hunt after abort.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      octSince  <= '0;
      huntTrack <= 1'b0;
    end else begin
      if (idleFlag) octSince <= '0;
      else if (byteStrobe && octSince != CNT_W'(MIN_OCTETS)) octSince <= octSince + 1'b1;
      if (idleFlag) huntTrack <= 1'b0;
      else if (fcsGood) huntTrack <= 1'b1;
    end
  end

  a_r2_flag_on_bus: assert property (@(posedge clk) disable iff (!rstN)
    idleFlag |-> (byteStrobe && dataOut == OCTET_W'(FLAG_OCTET)));

  a_r4_data_plain: assert property (@(posedge clk) disable iff (!rstN)
    (byteStrobe && !idleFlag) |-> !fcsGood);

  a_r7_abort_no_byte: assert property (@(posedge clk) disable iff (!rstN)
    (fcsGood && !idleFlag) |-> !byteStrobe);

  a_r8_hunt_silent: assert property (@(posedge clk) disable iff (!rstN)
    huntTrack |-> !(byteStrobe && !idleFlag));

  a_r9_min_octets: assert property (@(posedge clk) disable iff (!rstN)
    (idleFlag && fcsGood) |-> (octSince >= CNT_W'(MIN_OCTETS)));

  a_r12_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitValid) |-> !(byteStrobe || idleFlag || fcsGood));

endmodule

bind hdlcRxDeframer hdlcRxChecker #(
  .OCTET_W   (OCTET_W),
  .MIN_OCTETS(MIN_OCTETS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .dataOut   (dataOut),
  .byteStrobe(byteStrobe),
  .idleFlag  (idleFlag),
  .fcsGood   (fcsGood)
);

// File: tb/hdlcRxDeframer_bench.sv
module hdlcRxDeframer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic       bitValid = 1'b0;
  logic [7:0] dataOut;
  logic       byteStrobe, idleFlag, fcsGood;

  always #5 clk = ~clk;

  hdlcRxDeframer u_hdlcRxDeframer (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .dataOut(dataOut), .byteStrobe(byteStrobe), .idleFlag(idleFlag), .fcsGood(fcsGood)
  );

  typedef struct packed {
    logic       strobe;
    logic       idle;
    logic       fcs;
    logic [7:0] data;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    fails = 0;
  int    pulses = 0;
  int    benchOnes = 0;
  bit    gapMode = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic s, input logic i, input logic f,
                         input logic [7:0] d, input string tag);
    exp_t e;
    e.strobe = s; e.idle = i; e.fcs = f; e.data = d;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: every pulse on the outputs is matched against the scoreboard.
  always @(negedge clk) begin
    if (rstN && (byteStrobe || idleFlag || fcsGood)) begin
      exp_t  e;
      string t;
      pulses++;
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "unexpected pulse", {21'd0, byteStrobe, idleFlag, fcsGood, dataOut}, 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(byteStrobe == e.strobe && idleFlag == e.idle && fcsGood == e.fcs &&
              (!e.strobe || dataOut == e.data), t, "pulse {strobe,idle,fcs,data}",
              {21'd0, byteStrobe, idleFlag, fcsGood, dataOut}, {21'd0, e});
      end
    end
  end

  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic sendBit(input logic b);
    bitIn = b;
    bitValid = 1'b1;
    @(posedge clk); #1;
    bitValid = 1'b0;
    if (gapMode) begin
      bitIn = ~b;
      @(posedge clk); #1;
    end
  endtask

  // Data bit with zero insertion after five ones (R3).
  task automatic sendDataBit(input logic b);
    sendBit(b);
    if (b) begin
      benchOnes++;
      if (benchOnes == 5) begin
        sendBit(1'b0);
        benchOnes = 0;
      end
    end else begin
      benchOnes = 0;
    end
  endtask

  task automatic sendOctet(input logic [7:0] d, input bit expectIt, input string tag);
    if (expectIt) pushExp(1'b1, 1'b0, 1'b0, d, tag);
    for (int i = 0; i < 8; i++) sendDataBit(d[i]);
  endtask

  task automatic sendFlag(input bit good, input string tag);
    pushExp(1'b1, 1'b1, good, 8'h7E, tag);
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
    benchOnes = 0;
  endtask

  task automatic sendFrame(input logic [7:0] p[8], input int n, input bit corrupt,
                           input string tag);
    logic [15:0] crc;
    logic [15:0] fcs;
    crc = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      crc = benchCrc(crc, p[i]);
      sendOctet(p[i], 1'b1, "R4");
    end
    fcs = ~crc;
    if (corrupt) fcs[0] = ~fcs[0];
    sendOctet(fcs[7:0], 1'b1, "R4");
    sendOctet(fcs[15:8], 1'b1, "R4");
    sendFlag(!corrupt, tag);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    int snap;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!byteStrobe && !idleFlag && !fcsGood, "R1", "outputs in reset",
          {byteStrobe, idleFlag, fcsGood}, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!byteStrobe && !idleFlag && !fcsGood, "R1", "outputs after reset",
          {byteStrobe, idleFlag, fcsGood}, 0);
    check(dataOut == 8'h00, "R1", "dataOut after reset", dataOut, 0);
    @(posedge clk); #1;

    // R1/R2: idle flags; first leaves hunt as a plain flag
    sendFlag(1'b0, "R1");
    sendFlag(1'b0, "R2");
    sendFlag(1'b0, "R2");

    // R5: good frame
    sendFrame('{8'h12, 8'h34, 8'hA5, 0, 0, 0, 0, 0}, 3, 1'b0, "R5");
    // R3/R11: long ones runs, sharing the previous closing flag
    sendFrame('{8'hFF, 8'h7E, 8'h3F, 8'hF8, 0, 0, 0, 0}, 4, 1'b0, "R11");
    // R6: corrupted FCS
    sendFrame('{8'hFF, 8'h7E, 8'h3F, 8'hF8, 0, 0, 0, 0}, 4, 1'b1, "R6");
    // R3: payload whose octets carry stuffed zeros, checked bytewise
    sendFrame('{8'h1F, 8'hFC, 8'h7F, 0, 0, 0, 0, 0}, 3, 1'b0, "R3");

    // R9: one octet only, then exactly two (empty payload)
    sendOctet(8'h5A, 1'b1, "R9");
    sendFlag(1'b0, "R9");
    sendFrame('{0, 0, 0, 0, 0, 0, 0, 0}, 0, 1'b0, "R9");

    // R10: three bits past an octet boundary; 0xF5 leaks, flag is plain
    sendOctet(8'h21, 1'b1, "R10");
    sendOctet(8'h43, 1'b1, "R10");
    pushExp(1'b1, 1'b0, 1'b0, 8'hF5, "R10");
    sendDataBit(1'b1);
    sendDataBit(1'b0);
    sendDataBit(1'b1);
    sendFlag(1'b0, "R10");

    // R12: frame driven with invalid cycles between bits
    gapMode = 1;
    sendFrame('{8'hC3, 8'h3C, 0, 0, 0, 0, 0, 0}, 2, 1'b0, "R12");
    gapMode = 0;

    // R12: invalid cycles carrying a flag pattern have no effect
    @(negedge clk);
    snap = pulses;
    for (int i = 0; i < 32; i++) begin
      bitIn = (i % 8 != 0) && (i % 8 != 7);
      @(posedge clk); #1;
    end
    @(negedge clk);
    check(pulses == snap, "R12", "pulses while bitValid low", pulses, snap);
    @(posedge clk); #1;
    sendFrame('{8'h66, 0, 0, 0, 0, 0, 0, 0}, 1, 1'b0, "R12");

    // R7: abort after two octets
    sendOctet(8'h11, 1'b1, "R7");
    sendOctet(8'h11, 1'b1, "R7");
    pushExp(1'b0, 1'b0, 1'b1, 8'h00, "R7");
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    benchOnes = 0;

    // R8: data while hunting produces nothing
    repeat (2) @(negedge clk);
    snap = pulses;
    @(posedge clk); #1;
    sendOctet(8'h55, 1'b0, "R8");
    sendOctet(8'h55, 1'b0, "R8");
    sendOctet(8'h0F, 1'b0, "R8");
    repeat (2) @(negedge clk);
    check(pulses == snap, "R8", "pulses while hunting", pulses, snap);
    @(posedge clk); #1;
    sendFlag(1'b0, "R8");
    sendFrame('{8'h99, 0, 0, 0, 0, 0, 0, 0}, 1, 1'b0, "R8");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R4", "scoreboard drained", expQ.size(), 0);
    done = 1;
    report();
    $finish;
  end

endmodule